// File: doc/BRIEF.md
# Paired-Command Pin Control Register

This block is a 32-bit command/status register that owns the output level and the direction of a small group of general-purpose pins. A single write can carry commands for any number of pins. Each pin has two bit pairs. One pair drives the output level low or high. The other pair makes the pin an output or an input. A pin whose bits are not written is not touched. Software therefore never needs a read-modify-write to change one pin, even while other agents change other pins.

A read returns the status of each pin in the same bit positions that its commands use. The lower bit of the level pair reports the driven level. The upper bit of the level pair reports the pin's sampled input level, after a two-flop synchronizer, while the pin is an input. The direction pair reports the output-enable state and its complement.

The register has room for eight pin slots. A parameter sets how many of them are wired to pins, and a second copy of the block typically serves four. Unwired slots read as zero and ignore commands.

The bus side is a plain register port: a one-cycle write strobe with data, and a read value that is always present. No transfer on this port can stall, so the port carries no valid/ready handshake and never applies back-pressure.

Top module: `ext_pin_cmdreg`

## Requirements
- R1: While reset is asserted and right after it, every pin is an input (pin_oe = 0) and every output level is low (pin_out = 0).
- R2: A write with bit 2n+1 = 1 and bit 2n = 0 makes pin n drive high. A write with bit 2n = 1 and bit 2n+1 = 0 makes pin n drive low. The pin_out port changes on the clock edge that takes the write.
- R3: A write with bit 16+2n = 1 and bit 17+2n = 0 makes pin n an output. A write with bit 17+2n = 1 and bit 16+2n = 0 makes pin n an input. The pin_oe port changes on the clock edge that takes the write.
- R4: For each pin and each pair, a write whose two pair bits are equal (both 0 or both 1) leaves that pin's level or direction unchanged. When wr_en is 0, nothing changes.
- R5: A write changes only the pins whose command pairs it carries. Any mix of commands to different pins in one write is applied to all of those pins at the same time.
- R6: For an active pin n, rd_data bit 2n equals the driven level, bit 16+2n equals pin_oe[n], and bit 17+2n equals its inverse.
- R7: For an active pin n that is an input, rd_data bit 2n+1 shows pin_in[n] two clock edges after pin_in[n] changes, not one. While pin n is an output, that bit reads 0.
- R8: pin_out and pin_oe always carry the level and direction that rd_data reports.
- R9: Slots at or above NUM_PINS read 0 in all four of their bit positions, and writes to them have no effect on any pin.
- R10: Reading bit 2n and then writing a lone clear command (bit 2n) if that bit was 1, or a lone set command (bit 2n+1) if it was 0, inverts pin n and leaves every other pin unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; the command word is taken on the rising clock edge |
| wr_data | input | 32 | Command word holding the level and direction pairs |
| rd_data | output | 32 | Status word in the same bit positions |
| pin_in | input | NUM_PINS | Raw pin levels, asynchronous to clk |
| pin_out | output | NUM_PINS | Driven level for each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin (1 = output) |

## Verification
The level and direction pairs are driven with single-pair commands for each polarity, with both-zero and both-one pairs that must do nothing, and with long runs of random full-width words that mix every kind of pair across all pins. The single-pair commands show that set and clear, and enable and disable, are not swapped. The equal-bit pairs show that ambiguous commands are dropped rather than resolved. The random words expose any spill of one pin's command onto a neighbour, because every pin is compared after every write.

A separate input-level pattern steps one pin's input and samples the status after one edge and after two edges to prove the two-stage delay. A four-pin copy receives the same random words so that its unused upper slots are seen to stay zero. The toggle sequence closes the loop between the readback and the command encoding.

// File: rtl/ext_pin_pkg.sv
package ext_pin_pkg;

  // Register geometry fixed by the command encoding
  localparam int REG_W    = 32;
  localparam int HALF_W   = REG_W / 2;
  localparam int SLOTS    = HALF_W / 2;
  localparam int DIR_BASE = HALF_W;

  // Decoded meaning of one two-bit command pair
  typedef enum logic [1:0] {
    PAIR_IDLE  = 2'b00,
    PAIR_LOWER = 2'b01,   // only the lower bit of the pair written
    PAIR_UPPER = 2'b10    // only the upper bit of the pair written
  } pair_cmd_e;

  // Two equal bits (00 or 11) carry no command
  function automatic pair_cmd_e decode_pair(input logic [1:0] bits);
    pair_cmd_e r;
    unique case (bits)
      2'b01:   r = PAIR_LOWER;
      2'b10:   r = PAIR_UPPER;
      default: r = PAIR_IDLE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ext_pin_sync.sv
module ext_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;

endmodule

// File: rtl/ext_pin_cmd_decode.sv
module ext_pin_cmd_decode
  import ext_pin_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output pair_cmd_e        lvl_cmd [NUM_PINS],
  output pair_cmd_e        dir_cmd [NUM_PINS]
);

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_dec
    logic [1:0] lvl_bits;
    logic [1:0] dir_bits;

    assign lvl_bits = wr_data[2*n +: 2];
    assign dir_bits = wr_data[DIR_BASE + 2*n +: 2];

    always_comb begin
      lvl_cmd[n] = PAIR_IDLE;
      dir_cmd[n] = PAIR_IDLE;
      if (wr_en) begin
        lvl_cmd[n] = decode_pair(lvl_bits);
        dir_cmd[n] = decode_pair(dir_bits);
      end
    end
  end

endmodule

// File: rtl/ext_pin_slot.sv
module ext_pin_slot
  import ext_pin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pair_cmd_e lvl_cmd,
  input  pair_cmd_e dir_cmd,
  input  logic      pin_sync,
  output logic      level,
  output logic      oe,
  output logic [1:0] lvl_stat,
  output logic [1:0] dir_stat
);

  // Level pair: lower bit clears, upper bit sets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
    end else begin
      unique case (lvl_cmd)
        PAIR_LOWER: level <= 1'b0;
        PAIR_UPPER: level <= 1'b1;
        default:    level <= level;
      endcase
    end
  end

  // Direction pair: lower bit enables the driver, upper bit releases it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe <= 1'b0;
    end else begin
      unique case (dir_cmd)
        PAIR_LOWER: oe <= 1'b1;
        PAIR_UPPER: oe <= 1'b0;
        default:    oe <= oe;
      endcase
    end
  end

  // Status in command positions
  assign lvl_stat = {~oe & pin_sync, level};
  assign dir_stat = {~oe, oe};

endmodule

// File: rtl/ext_pin_cmdreg.sv
module ext_pin_cmdreg
  import ext_pin_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int FREE_SLOTS = SLOTS - NUM_PINS;

  pair_cmd_e         lvl_cmd [NUM_PINS];
  pair_cmd_e         dir_cmd [NUM_PINS];
  logic [NUM_PINS-1:0] pin_sync;

  ext_pin_sync #(.W(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  ext_pin_cmd_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .lvl_cmd (lvl_cmd),
    .dir_cmd (dir_cmd)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_PINS) begin : g_live
      logic [1:0] lvl_stat;
      logic [1:0] dir_stat;

      ext_pin_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_cmd  (lvl_cmd[s]),
        .dir_cmd  (dir_cmd[s]),
        .pin_sync (pin_sync[s]),
        .level    (pin_out[s]),
        .oe       (pin_oe[s]),
        .lvl_stat (lvl_stat),
        .dir_stat (dir_stat)
      );

      assign rd_data[2*s +: 2]            = lvl_stat;
      assign rd_data[DIR_BASE + 2*s +: 2] = dir_stat;
    end else begin : g_free
      assign rd_data[2*s +: 2]            = 2'b00;
      assign rd_data[DIR_BASE + 2*s +: 2] = 2'b00;
    end
  end

  initial begin
    if (NUM_PINS < 1 || FREE_SLOTS < 0)
      $error("NUM_PINS must be within 1..%0d", SLOTS);
  end

endmodule

// File: rtl/ext_pin_cmdreg_chk.sv
module ext_pin_cmdreg_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [31:0]         wr_data,
  input logic [31:0]         rd_data,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0 && pin_out == '0));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    // R2
    lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[2*n+1] && !wr_data[2*n]) |=> pin_out[n]);
    // R2
    lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[2*n+1] && wr_data[2*n]) |=> !pin_out[n]);
    // R3
    dir_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[16+2*n] && !wr_data[17+2*n]) |=> pin_oe[n]);
    // R3
    dir_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[16+2*n] && wr_data[17+2*n]) |=> !pin_oe[n]);
    // R4
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_data[2*n] == wr_data[2*n+1]) |=> $stable(pin_out[n]));
    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_data[16+2*n] == wr_data[17+2*n]) |=> $stable(pin_oe[n]));
    // R6
    rd_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[2*n] == pin_out[n] && rd_data[16+2*n] == pin_oe[n]
        && rd_data[17+2*n] == !pin_oe[n]);
    // R7
    out_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[n] |-> !rd_data[2*n+1]);
  end

  for (genvar u = NUM_PINS; u < 8; u++) begin : g_free
    // R9
    free_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[2*u +: 2] == 2'b00 && rd_data[16+2*u +: 2] == 2'b00);
  end

endmodule

bind ext_pin_cmdreg ext_pin_cmdreg_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/ext_pin_cmdreg_test.sv
`timescale 1ns/1ps
module ext_pin_cmdreg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a, rd_b;
  logic [7:0]  pin_in_a = '0, pin_out_a, pin_oe_a;
  logic [3:0]  pin_in_b = '0, pin_out_b, pin_oe_b;

  // bench model
  logic [7:0] m_lvl_a = '0, m_oe_a = '0;
  logic [3:0] m_lvl_b = '0, m_oe_b = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  ext_pin_cmdreg #(.NUM_PINS(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_a), .pin_in(pin_in_a), .pin_out(pin_out_a), .pin_oe(pin_oe_a)
  );

  ext_pin_cmdreg #(.NUM_PINS(4)) uut_q (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_b), .pin_in(pin_in_b), .pin_out(pin_out_b), .pin_oe(pin_oe_b)
  );

  function automatic logic [7:0] next_lvl(logic [7:0] cur, logic [31:0] d, int np);
    logic [7:0] r = cur;
    for (int n = 0; n < np; n++) begin
      if (d[2*n+1] && !d[2*n]) r[n] = 1'b1;
      if (!d[2*n+1] && d[2*n]) r[n] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [7:0] next_oe(logic [7:0] cur, logic [31:0] d, int np);
    logic [7:0] r = cur;
    for (int n = 0; n < np; n++) begin
      if (d[16+2*n] && !d[17+2*n]) r[n] = 1'b1;
      if (!d[16+2*n] && d[17+2*n]) r[n] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] lv, logic [7:0] oe,
                                         logic [7:0] pin, int np);
    logic [31:0] r = '0;
    for (int n = 0; n < np; n++) begin
      r[2*n]    = lv[n];
      r[2*n+1]  = ~oe[n] & pin[n];
      r[16+2*n] = oe[n];
      r[17+2*n] = ~oe[n];
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, rd_a, exp_rd(m_lvl_a, m_oe_a, pin_in_a, 8));
    check(req, rd_b, exp_rd({4'b0, m_lvl_b}, {4'b0, m_oe_b}, {4'b0, pin_in_b}, 4));
    check({req, "/R8 pins"}, {16'b0, pin_out_a, pin_oe_a}, {16'b0, m_lvl_a, m_oe_a});
    check({req, "/R8 pins_q"}, {24'b0, pin_out_b, pin_oe_b}, {24'b0, m_lvl_b, m_oe_b});
  endtask

  // drive one command plus new pin levels, then wait out the synchronizer
  task automatic cmd(logic [31:0] d, logic [7:0] pa, logic [3:0] pb);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; pin_in_a = pa; pin_in_b = pb;
    m_lvl_a = next_lvl(m_lvl_a, d, 8);
    m_oe_a  = next_oe(m_oe_a, d, 8);
    m_lvl_b = 4'(next_lvl({4'b0, m_lvl_b}, d, 4));
    m_oe_b  = 4'(next_oe({4'b0, m_oe_b}, d, 4));
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = $urandom;   // data with no strobe: R4
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    logic        b;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset", {pin_oe_a, pin_out_a, pin_oe_b, pin_out_b}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after");

    // R2: set and clear pin 3
    cmd(32'h0000_0080, '0, '0);
    check_all("R2 set");
    cmd(32'h0000_0040, '0, '0);
    check_all("R2 clear");
    // R3: enable and disable pin 2
    cmd(32'h0010_0000, '0, '0);
    check_all("R3 enable");
    cmd(32'h0000_0020, '0, '0);   // drive pin 2 high as output
    check_all("R3 level");
    cmd(32'h0020_0000, 8'h04, '0);
    check_all("R3 disable");
    // R4: both-one and both-zero pairs
    cmd(32'h0000_0020, '0, '0);   // pin 2 high
    cmd(32'h0030_0030, '0, '0);
    check_all("R4 both one");
    cmd(32'h0000_0000, '0, '0);
    check_all("R4 both zero");

    // R7: two-edge input delay on pin 0 (input)
    @(negedge clk);
    pin_in_a[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 one edge", {31'b0, rd_a[1]}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R7 two edges", {31'b0, rd_a[1]}, 32'd1);
    // R7: output pin hides its input
    cmd(32'h0004_0000, 8'h03, 4'h2);  // pin 1 output, pins 0 and 1 high
    check_all("R7 output");

    // R9: commands to unused slots of the four-pin copy
    cmd(32'h5500_AA00, 8'h03, 4'h2);
    check_all("R9 free");
    check("R9 free bits", rd_b & 32'hFF00_FF00, '0);

    // R10: toggle pin 5 as an output, twice
    cmd(32'h0400_0000, 8'h03, 4'h2);
    for (int t = 0; t < 2; t++) begin
      b = rd_a[10];
      cmd(b ? 32'h0000_0400 : 32'h0000_0800, 8'h03, 4'h2);
      check_all("R10 toggle");
      check("R10 flipped", {31'b0, pin_out_a[5]}, {31'b0, ~b});
    end

    // R5: random mixed commands
    for (int i = 0; i < 400; i++) begin
      cmd($urandom, 8'($urandom), 4'($urandom));
      check_all("R5 random");
    end

    finish_run();
  end

endmodule